// File: doc/BRIEF.md
# Parallel Switch Input Layer Spreader

This block sits on one input port of a parallel packet switch and spreads arriving fixed-length cells over several slower center-stage layers. One cell may arrive per external time slot (one clock cycle), carrying a payload and the number of the output it is bound for. Each layer is reached over its own link, which the surrounding logic paces with a per-layer ready strobe.

The layer for a cell is chosen from local state only. Each destination output keeps a round-robin pointer that names the single layer currently open for that output. The cell is stamped with the arrival slot number and written into that layer's FIFO, provided the FIFO has room. Whenever a layer's ready strobe is high and its FIFO holds a cell, the oldest cell is sent out on that layer's lane in the following cycle.

Each FIFO holds as many cells as the switch has ports, which keeps them from overflowing under correctly paced links. If a cell ever finds its chosen FIFO full, the cell is dropped and a sticky error flag is raised.

Top module: `pps_layer_spreader`

## Requirements
- R1: After reset every lane valid is low, the error flag is low, every per-output pointer names layer 0, and the slot counter reads 0 in the first cycle after reset is released.
- R2: A cell for output d is written into the FIFO of the layer named by d's pointer. After each accepted cell, d's pointer moves to the next layer (layer N_LAYERS-1 wraps to layer 0). Pointers of other outputs are unchanged.
- R3: A layer accepts a cell only while its occupancy is below N_PORTS. A cell leaving that FIFO in the same cycle still counts toward the occupancy.
- R4: A cell whose chosen layer is full is dropped and leaves its output's pointer unchanged. The error flag then goes high and stays high until reset.
- R5: Each accepted cell carries, as its stamp, the slot counter value of its arrival cycle. The slot counter advances by one every cycle and wraps at 2^STAMP_W.
- R6: When link_ready[l] is high and layer l's FIFO is non-empty at a clock edge, lane_valid[l] is high for the following cycle and carries that FIFO's oldest cell. Cells leave each FIFO in arrival order. Otherwise lane_valid[l] is low.
- R7: A cycle with in_valid low writes nothing into any FIFO, whatever in_data and in_dest hold.
- R8: The payload reaches the lane bit-for-bit unchanged. Lane l's payload occupies lane_data bits [l*CELL_W +: CELL_W], and its stamp occupies lane_stamp bits [l*STAMP_W +: STAMP_W].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one external time slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A cell is presented this slot |
| in_data | input | CELL_W | Cell payload |
| in_dest | input | $clog2(N_PORTS) | Destination output number |
| link_ready | input | N_LAYERS | Per-layer strobe: the link may take a cell this slot |
| lane_valid | output | N_LAYERS | Per-layer cell valid, one cycle per cell |
| lane_data | output | N_LAYERS*CELL_W | Per-layer payloads, packed by layer |
| lane_stamp | output | N_LAYERS*STAMP_W | Per-layer arrival stamps, packed by layer |
| drop_err | output | 1 | Sticky flag: a cell found its chosen layer full |

## Verification
On every cycle, assertions check several properties. No FIFO is written beyond its length or written while full. At most one FIFO is written per slot, and none is written without in_valid. A lane fires only after its ready strobe. Pointers move only on an accepted cell, and the error flag never falls outside reset. Only the bench scenarios can show that the right cell reaches the right lane with the right stamp, in order. The same holds for the wrap of each pointer through all layers, and for a full layer refusing a cell while it is also sending one. They also show that a dropped cell leaves its pointer where it was.

// File: rtl/pps_spread_pkg.sv
package pps_spread_pkg;

  // Advance an index by one, wrapping at lim.
  function automatic int wrap_inc(input int cur, input int lim);
    return (cur >= lim - 1) ? 0 : cur + 1;
  endfunction

  // True when an occupancy leaves room for one more cell.
  function automatic bit has_room(input int occ, input int depth);
    return occ < depth;
  endfunction

endpackage

// File: rtl/pps_slot_clock.sv
module pps_slot_clock #(
  parameter int STAMP_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [STAMP_W-1:0] slot_now
);
  always_ff @(posedge clk) begin
    if (!rst_n) slot_now <= '0;
    else        slot_now <= slot_now + 1'b1;
  end

  // R5: the counter advances by exactly one per slot
  assert_slot_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slot_now == $past(slot_now) + 1'b1);
endmodule

// File: rtl/pps_rr_table.sv
module pps_rr_table #(
  parameter int N_PORTS  = 4,
  parameter int N_LAYERS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(N_PORTS)-1:0]  query_dest,
  output logic [$clog2(N_LAYERS)-1:0] open_layer,
  input  logic                        advance
);
  import pps_spread_pkg::*;
  localparam int DW = $clog2(N_PORTS);
  localparam int LW = $clog2(N_LAYERS);

  logic [N_PORTS-1:0][LW-1:0] ptr_q;

  assign open_layer = ptr_q[query_dest];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (advance) begin
      ptr_q[query_dest] <= LW'(wrap_inc(int'(ptr_q[query_dest]), N_LAYERS));
    end
  end

  // R2/R4: pointers move only when a cell was accepted
  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(ptr_q));
  // R2: an accepted cell changes the pointer of its destination
  assert_ptr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> ptr_q != $past(ptr_q));
endmodule

// File: rtl/pps_lane_fifo.sv
module pps_lane_fifo #(
  parameter int DEPTH   = 4,
  parameter int CELL_W  = 32,
  parameter int STAMP_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [CELL_W-1:0]          push_data,
  input  logic [STAMP_W-1:0]         push_stamp,
  input  logic                       pop_req,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic                       lane_valid,
  output logic [CELL_W-1:0]          lane_data,
  output logic [STAMP_W-1:0]         lane_stamp
);
  import pps_spread_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [CELL_W-1:0]  mem_data  [DEPTH];
  logic [STAMP_W-1:0] mem_stamp [DEPTH];
  logic [AW-1:0]      wr_idx, rd_idx;
  logic               do_pop;

  assign do_pop = pop_req && (occupancy != '0);

  always_ff @(posedge clk) begin
    if (push) begin
      mem_data[wr_idx]  <= push_data;
      mem_stamp[wr_idx] <= push_stamp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx     <= '0;
      rd_idx     <= '0;
      occupancy  <= '0;
      lane_valid <= 1'b0;
      lane_data  <= '0;
      lane_stamp <= '0;
    end else begin
      if (push)   wr_idx <= AW'(wrap_inc(int'(wr_idx), DEPTH));
      if (do_pop) rd_idx <= AW'(wrap_inc(int'(rd_idx), DEPTH));
      occupancy  <= occupancy + OW'(push) - OW'(do_pop);
      lane_valid <= do_pop;
      if (do_pop) begin
        lane_data  <= mem_data[rd_idx];
        lane_stamp <= mem_stamp[rd_idx];
      end
    end
  end

  // R3: occupancy never exceeds the FIFO length
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OW'(DEPTH));
  // R3: the selector never writes a full FIFO
  assert_push_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> occupancy < OW'(DEPTH));
  // R6: a lane fires only in the cycle after its ready strobe
  assert_lane_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_valid |-> $past(pop_req));
  // R6: an empty FIFO sends nothing
  assert_empty_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0 && !push) |=> occupancy == '0);
endmodule

// File: rtl/pps_layer_spreader.sv
module pps_layer_spreader #(
  parameter int N_PORTS  = 4,
  parameter int N_LAYERS = 4,
  parameter int CELL_W   = 32,
  parameter int STAMP_W  = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [CELL_W-1:0]            in_data,
  input  logic [$clog2(N_PORTS)-1:0]   in_dest,
  input  logic [N_LAYERS-1:0]          link_ready,
  output logic [N_LAYERS-1:0]          lane_valid,
  output logic [N_LAYERS*CELL_W-1:0]   lane_data,
  output logic [N_LAYERS*STAMP_W-1:0]  lane_stamp,
  output logic                         drop_err
);
  import pps_spread_pkg::*;
  localparam int LW    = $clog2(N_LAYERS);
  localparam int DEPTH = N_PORTS;
  localparam int OW    = $clog2(DEPTH + 1);

  logic [STAMP_W-1:0]  slot_now;
  logic [LW-1:0]       open_layer;
  logic [N_LAYERS-1:0] room_vec;
  logic [N_LAYERS-1:0] push_vec;
  logic                accept;
  logic                drop_now;

  pps_slot_clock #(.STAMP_W(STAMP_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .slot_now(slot_now));

  pps_rr_table #(.N_PORTS(N_PORTS), .N_LAYERS(N_LAYERS)) u_rr (
    .clk(clk), .rst_n(rst_n), .query_dest(in_dest),
    .open_layer(open_layer), .advance(accept));

  // Layer choice: the destination's open layer, if that FIFO has room.
  assign accept   = in_valid &&  room_vec[open_layer];
  assign drop_now = in_valid && !room_vec[open_layer];

  generate
    for (genvar l = 0; l < N_LAYERS; l++) begin : g_lane
      logic [OW-1:0] occ;
      assign push_vec[l] = accept && (open_layer == LW'(l));
      assign room_vec[l] = has_room(int'(occ), DEPTH);
      pps_lane_fifo #(.DEPTH(DEPTH), .CELL_W(CELL_W), .STAMP_W(STAMP_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push_vec[l]), .push_data(in_data), .push_stamp(slot_now),
        .pop_req(link_ready[l]), .occupancy(occ),
        .lane_valid(lane_valid[l]),
        .lane_data(lane_data[l*CELL_W +: CELL_W]),
        .lane_stamp(lane_stamp[l*STAMP_W +: STAMP_W]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        drop_err <= 1'b0;
    else if (drop_now) drop_err <= 1'b1;
  end

  // R2: at most one FIFO is written per slot
  assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_vec));
  // R7: nothing is written without a valid cell
  assert_idle_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> push_vec == '0);
  // R4: the error flag is sticky
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drop_err) |-> drop_err);
  // R4: a refused cell raises the flag in the next cycle
  assert_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && push_vec == '0) |=> drop_err);
endmodule

// File: tb/pps_layer_spreader_test.sv
module pps_layer_spreader_test;
  localparam int NP = 4;
  localparam int NL = 4;
  localparam int CW = 32;
  localparam int SW = 12;
  localparam int DW = $clog2(NP);
  localparam int DEPTH = NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CW-1:0] in_data = '0;
  logic [DW-1:0] in_dest = '0;
  logic [NL-1:0] link_ready = '0;
  logic [NL-1:0] lane_valid;
  logic [NL*CW-1:0] lane_data;
  logic [NL*SW-1:0] lane_stamp;
  logic drop_err;

  always #2 clk = ~clk;

  pps_layer_spreader #(.N_PORTS(NP), .N_LAYERS(NL), .CELL_W(CW), .STAMP_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_dest(in_dest), .link_ready(link_ready), .lane_valid(lane_valid),
    .lane_data(lane_data), .lane_stamp(lane_stamp), .drop_err(drop_err));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  logic [CW-1:0] mq_d [NL][DEPTH];
  logic [SW-1:0] mq_s [NL][DEPTH];
  int            mq_n [NL];
  int            m_ptr [NP];
  logic [SW-1:0] m_slot;
  logic          m_err;
  logic [NL-1:0] e_valid;
  logic [CW-1:0] e_data [NL];
  logic [SW-1:0] e_stamp [NL];

  function automatic int next_lane(input int cur);
    return (cur + 1) % NL;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int l = 0; l < NL; l++) begin
      mq_n[l] = 0; e_valid[l] = 1'b0; e_data[l] = '0; e_stamp[l] = '0;
    end
    for (int d = 0; d < NP; d++) m_ptr[d] = 0;
    m_slot = '0;
    m_err = 1'b0;
  endtask

  task automatic model_step(input logic v, input logic [CW-1:0] d,
                            input logic [DW-1:0] ds, input logic [NL-1:0] rdy);
    int pre [NL];
    for (int l = 0; l < NL; l++) pre[l] = mq_n[l];
    for (int l = 0; l < NL; l++) begin
      if (rdy[l] && mq_n[l] > 0) begin
        e_valid[l] = 1'b1; e_data[l] = mq_d[l][0]; e_stamp[l] = mq_s[l][0];
        for (int i = 0; i < DEPTH - 1; i++) begin
          mq_d[l][i] = mq_d[l][i+1]; mq_s[l][i] = mq_s[l][i+1];
        end
        mq_n[l]--;
      end else begin
        e_valid[l] = 1'b0;
      end
    end
    if (v) begin
      int tl = m_ptr[ds];
      if (pre[tl] < DEPTH) begin
        mq_d[tl][mq_n[tl]] = d; mq_s[tl][mq_n[tl]] = m_slot;
        mq_n[tl]++;
        m_ptr[ds] = next_lane(tl);
      end else begin
        m_err = 1'b1;
      end
    end
    m_slot = m_slot + 1'b1;
  endtask

  task automatic compare_all();
    for (int l = 0; l < NL; l++) begin
      check(lane_valid[l] == e_valid[l], "R6", $sformatf("lane %0d valid", l),
            64'(lane_valid[l]), 64'(e_valid[l]));
      if (e_valid[l] && lane_valid[l]) begin
        check(lane_data[l*CW +: CW] == e_data[l], "R2", $sformatf("lane %0d data", l),
              64'(lane_data[l*CW +: CW]), 64'(e_data[l]));
        check(lane_stamp[l*SW +: SW] == e_stamp[l], "R5", $sformatf("lane %0d stamp", l),
              64'(lane_stamp[l*SW +: SW]), 64'(e_stamp[l]));
      end
    end
    check(drop_err == m_err, "R4", "drop flag", 64'(drop_err), 64'(m_err));
  endtask

  // Drive at the falling edge, evaluate one rising edge, sample 1 ns later.
  task automatic step(input logic v, input logic [CW-1:0] d,
                      input logic [DW-1:0] ds, input logic [NL-1:0] rdy);
    in_valid = v; in_data = d; in_dest = ds; link_ready = rdy;
    @(posedge clk);
    model_step(v, d, ds, rdy);
    #1;
    compare_all();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; link_ready = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: quiet outputs straight after reset
    check(lane_valid == '0, "R1", "lanes after reset", 64'(lane_valid), 0);
    check(drop_err == 1'b0, "R1", "flag after reset", 64'(drop_err), 0);

    // R1/R5/R8: first cell to output 3 lands in layer 0 with stamp 0
    step(1'b1, 32'hCAFE_0001, 2'd3, '0);
    step(1'b0, '0, '0, 4'b0001);
    check(lane_valid == 4'b0001, "R1", "first cell on layer 0", 64'(lane_valid), 1);
    check(lane_data[CW-1:0] == 32'hCAFE_0001, "R8", "payload intact",
          64'(lane_data[CW-1:0]), 64'h CAFE_0001);
    check(lane_stamp[SW-1:0] == '0, "R5", "first stamp", 64'(lane_stamp[SW-1:0]), 0);

    // R2: output 3 now points at layer 1, output 0 still at layer 0
    step(1'b1, 32'h0000_0B03, 2'd3, '0);
    step(1'b1, 32'h0000_0B00, 2'd0, '0);
    step(1'b0, '0, '0, 4'b0011);
    check(lane_valid == 4'b0011, "R2", "per-output pointers", 64'(lane_valid), 3);

    // R7: idle slots with junk on the inputs write nothing
    for (int i = 0; i < 6; i++) begin
      in_data = $urandom; in_dest = 2'(i);
      step(1'b0, 32'hDEAD_0000 + 32'(i), DW'(i), '0);
    end
    step(1'b0, '0, '0, '1);
    check(lane_valid == '0, "R7", "no cell after idle slots", 64'(lane_valid), 0);

    // R3/R4: fill every layer, then refuse a cell while its layer is popping
    do_reset();
    for (int i = 0; i < NL * DEPTH; i++) step(1'b1, 32'h1000 + 32'(i), 2'd0, '0);
    check(drop_err == 1'b0, "R3", "no drop while filling", 64'(drop_err), 0);
    step(1'b1, 32'h2222, 2'd0, 4'b0001);
    check(drop_err == 1'b1, "R3", "full layer refuses despite same-slot pop",
          64'(drop_err), 1);
    for (int i = 0; i < 3 * DEPTH; i++) step(1'b0, '0, '0, '1);
    check(drop_err == 1'b1, "R4", "flag stays set", 64'(drop_err), 1);
    step(1'b1, 32'h3333, 2'd0, '0);
    step(1'b0, '0, '0, '1);
    check(lane_valid == 4'b0001, "R4", "pointer unchanged after drop",
          64'(lane_valid), 1);

    // Random traffic: links paced one layer per slot, bursts with links stalled
    do_reset();
    for (int i = 0; i < 6000; i++) begin
      logic [NL-1:0] rdy;
      logic v;
      v = ($urandom_range(0, 9) < 8);
      rdy = ((i / 500) % 3 == 2) ? '0 : NL'(1) << (i % NL);
      step(v, $urandom, DW'($urandom_range(0, NP - 1)), rdy);
    end
    for (int i = 0; i < 4 * DEPTH * NL; i++) step(1'b0, '0, '0, '1);

    // Random with every link always ready: no drops expected
    do_reset();
    for (int i = 0; i < 3000; i++)
      step(1'b1, $urandom, DW'($urandom_range(0, NP - 1)), '1);
    check(drop_err == 1'b0, "R3", "no drop with free links", 64'(drop_err), 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule